// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Front-End Slave

This block is the slave-side front end of a serial flash device that holds two byte-wide SRAM buffers. A host talks to it over a four-wire SPI link in mode 0, framed by an active-low chip select. The block decodes the first byte of each frame as an opcode, takes a three-byte address for buffer commands, and then streams data into or out of the chosen buffer until chip select is released. The pointer wraps at the end of the buffer. It also answers status reads, and it has a deep power-down state that only a dedicated wake opcode can leave.

All SPI inputs are oversampled by the system clock through a two-flop synchroniser. MOSI is captured on the detected SCLK rising edge. MISO is updated on the detected falling edge. The buffer depth, the wake-up guard time and the length of the busy window that follows a buffer write are parameters. The defaults are 1024 bytes, 35 us at 100 MHz, and 2000 cycles.

Top module: `dual_buf_flash_slave`

## Requirements
- R1: Opcode 0x84 writes buffer A and 0x87 writes buffer B. Opcode 0xD4 is a fast read of buffer A and 0xD6 a fast read of buffer B. Opcode 0xD1 is a slow read of buffer A and 0xD3 a slow read of buffer B. A write to one buffer never changes the other.
- R2: Every buffer opcode is followed by three address bytes. The first is ignored. Bits 1:0 of the second are offset bits 9:8, and the third is offset bits 7:0. The 10-bit offset is reduced modulo BUF_DEPTH.
- R3: After the address, each complete byte of a write frame is stored at successive offsets until chip select rises.
- R4: A fast read returns one dummy byte after the address and then data from the offset. A slow read returns data from the offset at once. All bytes go MSB first: MISO changes after the SCLK falling edge and MOSI is taken on the rising edge.
- R5: After offset BUF_DEPTH-1, both reads and writes continue at offset 0.
- R6: A rising chip select resets the decoder, so the next byte is an opcode. A byte left incomplete is discarded.
- R7: After opcode 0xD7, every byte clocked while chip select stays low returns the ready flag in bit 7, with bits 6:0 zero.
- R8: When a write frame that stored at least one byte ends, the ready flag is 0 for BUSY_CYC cycles. A write frame that stored no byte causes no busy window.
- R9: Opcode 0xB9 enters power-down when chip select rises. In power-down every opcode except 0xAB is ignored, including writes, and MISO stays high.
- R10: Opcode 0xAB in power-down starts a wake-up when chip select rises. Frames are ignored until chip select has been high for RESUME_CYC consecutive cycles. A frame that starts earlier restarts that count.
- R11: MISO is high out of reset, while chip select is high, and in any frame that has no active read phase, including frames with an unknown opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, high when not reading |

## Verification
The bound checker watches these rules on every cycle:
- Only one buffer is ever written at a time.
- A write at the last location moves the pointer back to zero.
- A chip select release clears the decoder.
- The ready flag drops as soon as a busy window opens.
- MISO stays high during power-down.
- No command is taken during wake-up.

Other behaviours need the bench's frame sequences, because they only show up at the pins:
- The order of data bytes.
- The dummy byte of fast reads.
- The use of the upper offset bits.
- Dropping of partial bytes.
- Writes lost in power-down.
- The exact end of the wake-up guard time.

// File: rtl/flash_buf_pkg.sv
package flash_buf_pkg;

  localparam logic [7:0] OP_WR_A  = 8'h84;
  localparam logic [7:0] OP_WR_B  = 8'h87;
  localparam logic [7:0] OP_RDH_A = 8'hD4;
  localparam logic [7:0] OP_RDH_B = 8'hD6;
  localparam logic [7:0] OP_RDL_A = 8'hD1;
  localparam logic [7:0] OP_RDL_B = 8'hD3;
  localparam logic [7:0] OP_STAT  = 8'hD7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    CM_OPC, CM_WR, CM_RDH, CM_RDL, CM_STAT, CM_DPD, CM_RES, CM_SKIP
  } cmd_e;

  typedef enum logic [1:0] {PW_ON, PW_DOWN, PW_WAKE} pwr_e;

  typedef struct packed {
    cmd_e cmd;
    logic sel;
  } dec_t;

  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d.cmd = CM_SKIP;
    d.sel = 1'b0;
    case (op)
      OP_WR_A:  d.cmd = CM_WR;
      OP_WR_B:  begin d.cmd = CM_WR;  d.sel = 1'b1; end
      OP_RDH_A: d.cmd = CM_RDH;
      OP_RDH_B: begin d.cmd = CM_RDH; d.sel = 1'b1; end
      OP_RDL_A: d.cmd = CM_RDL;
      OP_RDL_B: begin d.cmd = CM_RDL; d.sel = 1'b1; end
      OP_STAT:  d.cmd = CM_STAT;
      OP_SLEEP: d.cmd = CM_DPD;
      OP_WAKE:  d.cmd = CM_RES;
      default:  d.cmd = CM_SKIP;
    endcase
    return d;
  endfunction

  // offset bits 9:8 come from the low two bits of the middle address byte
  function automatic logic [9:0] join_off(input logic [1:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [9:0] fold_off(input logic [9:0] off, input int unsigned depth);
    return 10'((32'(off)) % depth);
  endfunction

  function automatic logic [9:0] step_off(input logic [9:0] p, input int unsigned depth);
    return ((32'(p) + 32'd1) >= depth) ? 10'd0 : p + 10'd1;
  endfunction

endpackage

// File: rtl/spi_front.sv
module spi_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       cs_act,
  output logic       cs_rise,
  output logic       sclk_fall,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] sclk_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] sr;
  logic       sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign cs_act    = ~cs_q[1];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign sclk_rise = sclk_q[1] & ~sclk_q[2] & cs_act;
  assign sclk_fall = ~sclk_q[1] & sclk_q[2] & cs_act;
  assign byte_done = sclk_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {sr, mosi_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= 3'd0;
      sr      <= 7'd0;
    end else if (!cs_act) begin
      bit_cnt <= 3'd0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sr      <= {sr[5:0], mosi_q[1]};
    end
  end
endmodule

// File: rtl/pwr_ctl.sv
import flash_buf_pkg::*;

module pwr_ctl #(
  parameter int RESUME_CYC = 3500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_rise,
  input  logic cs_high,
  input  logic req_down,
  input  logic req_resume,
  output pwr_e state
);
  localparam int CW = $clog2(RESUME_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PW_ON;
      cnt   <= '0;
    end else begin
      case (state)
        PW_ON:   if (cs_rise && req_down) state <= PW_DOWN;
        PW_DOWN: if (cs_rise && req_resume) begin
                   state <= PW_WAKE;
                   cnt   <= '0;
                 end
        PW_WAKE: if (!cs_high) cnt <= '0;
                 else if (cnt == CW'(RESUME_CYC - 1)) state <= PW_ON;
                 else cnt <= cnt + 1'b1;
        default: state <= PW_ON;
      endcase
    end
  end
endmodule

// File: rtl/buf_bank.sv
module buf_bank #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic [1:0]    wr_hit
);
  logic [7:0] rd_v [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [DEPTH];
    assign wr_hit[b] = we && (wsel == 1'(b));
    always_ff @(posedge clk) begin
      if (wr_hit[b]) mem[waddr] <= wdata;
    end
    assign rd_v[b] = mem[raddr];
  end

  assign rdata = rsel ? rd_v[1] : rd_v[0];
endmodule

// File: rtl/dual_buf_flash_slave.sv
import flash_buf_pkg::*;

module dual_buf_flash_slave #(
  parameter int BUF_DEPTH  = 1024,
  parameter int RESUME_CYC = 3500,
  parameter int BUSY_CYC   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic       cs_act, cs_rise, sclk_fall, byte_done;
  logic [7:0] rx_byte;

  cmd_e       cmd;
  logic       sel;
  logic [2:0] idx;
  logic [1:0] off_hi;
  logic [9:0] ptr;
  logic       wrote;
  logic [7:0] tx_next, tx_sr;
  logic       tx_pend, miso_q, rd_active;
  logic [BW-1:0] busy_cnt;
  pwr_e       pw_state;

  // named events for the checker
  dec_t       op_dec;
  cmd_e       op_cmd;
  logic [9:0] addr_now, fetch_addr;
  logic       fetch, wr_now, stat_load, busy_start, ready;
  logic [7:0] rd_data, stat_byte;
  logic [1:0] wr_hit;
  logic       is_buf;

  spi_front u_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .cs_act(cs_act), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  pwr_ctl #(.RESUME_CYC(RESUME_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_high(~cs_act),
    .req_down(cmd == CM_DPD), .req_resume(cmd == CM_RES), .state(pw_state)
  );

  buf_bank #(.DEPTH(BUF_DEPTH)) u_bank (
    .clk(clk), .we(wr_now), .wsel(sel), .waddr(ptr[AW-1:0]), .wdata(rx_byte),
    .rsel(sel), .raddr(fetch_addr[AW-1:0]), .rdata(rd_data), .wr_hit(wr_hit)
  );

  always_comb begin
    op_dec = decode_op(rx_byte);
    if (pw_state == PW_ON)
      op_cmd = op_dec.cmd;
    else if (pw_state == PW_DOWN && rx_byte == OP_WAKE)
      op_cmd = CM_RES;
    else
      op_cmd = CM_SKIP;
  end

  assign is_buf     = (cmd == CM_WR) || (cmd == CM_RDH) || (cmd == CM_RDL);
  assign addr_now   = fold_off(join_off(off_hi, rx_byte), BUF_DEPTH);
  assign fetch      = byte_done && (((cmd == CM_RDL) && (idx >= 3'd3)) ||
                                    ((cmd == CM_RDH) && (idx >= 3'd4)));
  assign fetch_addr = ((cmd == CM_RDL) && (idx == 3'd3)) ? addr_now : ptr;
  assign wr_now     = byte_done && (cmd == CM_WR) && (idx >= 3'd4);
  assign stat_load  = byte_done && (((idx == 3'd0) && (op_cmd == CM_STAT)) ||
                                    ((idx != 3'd0) && (cmd == CM_STAT)));
  assign ready      = (busy_cnt == '0);
  assign stat_byte  = {ready, 7'b0};
  assign busy_start = cs_rise && (cmd == CM_WR) && wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy_start) busy_cnt <= BW'(BUSY_CYC);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= CM_OPC;
      sel       <= 1'b0;
      idx       <= 3'd0;
      off_hi    <= 2'd0;
      ptr       <= 10'd0;
      wrote     <= 1'b0;
      tx_next   <= 8'hFF;
      tx_pend   <= 1'b0;
      tx_sr     <= 8'hFF;
      miso_q    <= 1'b1;
      rd_active <= 1'b0;
    end else if (!cs_act) begin
      cmd       <= CM_OPC;
      idx       <= 3'd0;
      wrote     <= 1'b0;
      tx_pend   <= 1'b0;
      miso_q    <= 1'b1;
      rd_active <= 1'b0;
    end else begin
      if (byte_done) begin
        if (idx != 3'd7) idx <= idx + 3'd1;
        if (idx == 3'd0) begin
          cmd <= op_cmd;
          sel <= op_dec.sel;
        end
        if (idx == 3'd2) off_hi <= rx_byte[1:0];
        if (idx == 3'd3 && is_buf)
          ptr <= (cmd == CM_RDL) ? step_off(addr_now, BUF_DEPTH) : addr_now;
        else if (fetch || wr_now)
          ptr <= step_off(ptr, BUF_DEPTH);
        if (wr_now) wrote <= 1'b1;
        if (fetch) begin
          tx_next <= rd_data;
          tx_pend <= 1'b1;
        end else if (stat_load) begin
          tx_next <= stat_byte;
          tx_pend <= 1'b1;
        end
      end
      if (sclk_fall) begin
        if (tx_pend) begin
          miso_q    <= tx_next[7];
          tx_sr     <= {tx_next[6:0], 1'b1};
          tx_pend   <= 1'b0;
          rd_active <= 1'b1;
        end else begin
          miso_q <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b1};
        end
      end
    end
  end

  assign miso = rd_active ? miso_q : 1'b1;
endmodule

// File: rtl/flash_slave_chk.sv
import flash_buf_pkg::*;

module flash_slave_chk #(
  parameter int BUF_DEPTH = 1024,
  parameter int BUSY_CYC  = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       miso,
  input pwr_e       pw_state,
  input logic       cs_rise,
  input logic [2:0] idx,
  input cmd_e       cmd,
  input logic       busy_start,
  input logic       ready,
  input logic [1:0] wr_hit,
  input logic [9:0] ptr
);
  a_r9_down_miso_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_state == PW_DOWN) |-> miso);

  a_r6_cs_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> ((idx == 3'd0) && (cmd == CM_OPC)));

  a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && (BUSY_CYC > 0)) |=> !ready);

  a_r10_wake_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_state == PW_WAKE) |-> ((cmd == CM_OPC) || (cmd == CM_SKIP)));

  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  a_r5_wrap_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hit != 2'b00) && (ptr == 10'(BUF_DEPTH - 1))) |=> (ptr == 10'd0));
endmodule

bind dual_buf_flash_slave flash_slave_chk #(.BUF_DEPTH(BUF_DEPTH), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .pw_state(pw_state), .cs_rise(cs_rise),
  .idx(idx), .cmd(cmd), .busy_start(busy_start), .ready(ready), .wr_hit(wr_hit), .ptr(ptr)
);

// File: tb/sim_dual_buf_flash_slave.sv
module sim_dual_buf_flash_slave;
  localparam int DEPTH = 96;
  localparam int RES   = 300;
  localparam int BUSY  = 400;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  always #5 clk = ~clk;

  dual_buf_flash_slave #(.BUF_DEPTH(DEPTH), .RESUME_CYC(RES), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] refm [2][DEPTH];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, g, e);
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wclk(8);
      rx[i] = miso;
      sclk = 1'b1;
      wclk(8);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_bits(input int n, input logic [7:0] tx);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wclk(8);
      sclk = 1'b1;
      wclk(8);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_lo();
    cs_n = 1'b0;
    wclk(8);
  endtask

  task automatic sel_hi();
    sclk = 1'b0;
    cs_n = 1'b1;
    wclk(16);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    spi_xfer(b, r);
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    logic [7:0] r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    spi_xfer(8'h00, r);
    got_q.push_back(r);
  endtask

  task automatic addr(input logic [9:0] off);
    send(8'h5A);
    send({6'b110011, off[9:8]});
    send(off[7:0]);
  endtask

  task automatic wr_txn(input bit b, input logic [9:0] off, input int n, input logic [7:0] seed);
    logic [7:0] d;
    sel_lo();
    send(b ? 8'h87 : 8'h84);
    addr(off);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 13);
      send(d);
      refm[b][(int'(off) + k) % DEPTH] = d;
    end
    sel_hi();
  endtask

  task automatic rd_txn(input bit b, input bit hs, input logic [9:0] off, input int n, input string tag);
    sel_lo();
    if (hs) send(b ? 8'hD6 : 8'hD4);
    else    send(b ? 8'hD3 : 8'hD1);
    addr(off);
    if (hs) send(8'h00);
    for (int k = 0; k < n; k++)
      read_expect(refm[b][(int'(off) + k) % DEPTH], tag);
    sel_hi();
  endtask

  task automatic stat_txn(input int n, input logic [7:0] exp, input string tag);
    sel_lo();
    send(8'hD7);
    for (int k = 0; k < n; k++) read_expect(exp, tag);
    sel_hi();
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk("R11 miso after reset", {7'b0, miso}, 8'h01);

    stat_txn(3, 8'h80, "R7 status ready on every byte");

    // offset 0x105 folds to 261 % 96 = 69, which needs offset bits 9:8
    wr_txn(1'b0, 10'h105, 8, 8'h11);
    wclk(BUSY + 50);
    rd_txn(1'b0, 1'b0, 10'h105, 8, "R2 R3 R4 slow read of buffer A");
    chk("R11 miso idle after read", {7'b0, miso}, 8'h01);

    wr_txn(1'b1, 10'h105, 8, 8'h60);
    stat_txn(2, 8'h00, "R8 busy after write");
    wclk(BUSY + 50);
    stat_txn(1, 8'h80, "R8 ready after window");
    rd_txn(1'b1, 1'b1, 10'h105, 8, "R1 R4 fast read of buffer B");
    rd_txn(1'b0, 1'b1, 10'h105, 8, "R1 buffer A untouched");

    wr_txn(1'b0, 10'd94, 4, 8'hC0);
    wclk(BUSY + 50);
    rd_txn(1'b0, 1'b0, 10'd94, 4, "R5 wrap of write and read");

    // partial data byte is dropped and starts no busy window
    sel_lo(); send(8'h84); addr(10'h105); spi_bits(4, 8'hFF); sel_hi();
    stat_txn(1, 8'h80, "R8 empty write gives no busy");
    rd_txn(1'b0, 1'b0, 10'h105, 1, "R6 partial byte discarded");

    // partial opcode, then a clean frame
    sel_lo(); spi_bits(3, 8'hFF); sel_hi();
    stat_txn(1, 8'h80, "R6 decoder reset by chip select");

    sel_lo(); send(8'h00);
    read_expect(8'hFF, "R11 unknown opcode keeps miso high");
    read_expect(8'hFF, "R11 unknown opcode keeps miso high");
    sel_hi();

    sel_lo(); send(8'hB9); sel_hi();
    stat_txn(2, 8'hFF, "R9 status ignored in power-down");
    sel_lo(); send(8'h87); addr(10'h105); send(8'h3C); sel_hi();

    sel_lo(); send(8'hAB); sel_hi();
    stat_txn(1, 8'hFF, "R10 frame before guard time ignored");
    wclk(RES + 50);
    stat_txn(1, 8'h80, "R10 accepted after guard time");
    rd_txn(1'b1, 1'b0, 10'h105, 2, "R9 write in power-down ignored");

    wclk(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule